// File: doc/BRIEF.md
# Three-Channel Display Interrupt Controller

This block holds the control word and the event status word of a three-channel display compositor. Each channel presents raw timing and error conditions: a run/stop mode level, FIFO read requests against an empty FIFO, line and frame starts arriving while pixels are still pending, end-of-line-N pulses and low-watermark pulses. The block turns these conditions into sticky per-channel flags. It also keeps a DMA error flag, a profiler flag and the most recent bus response code.

Per-event enable bits in the control word decide which flags feed each channel's summary bit. A second set of per-channel enables, together with the profiler enable, decides which sources drive the single registered interrupt line. Software uses a one-word-select register port. It reads and writes the control word, clears individual flags by writing ones to them, and clears every interrupt flag at once through status bit 0.

Top module: `disp_irq_ctrl`

## Requirements
- R1: After reset the control word, the status word and `irq_o` all read 0.
- R2: Only control bits 31 and 15:0 are writable. Every other control bit reads 0. Bit 31 is the block enable, bit 1+ch the channel interrupt enable, bit 0 the profiler interrupt enable and bit 4 the DMA summary enable.
- R3: For channel ch, with base b = 8+8·ch, status bit b+1 sets on a read request while the FIFO is empty. Bit b+2 sets on a line start while pixels are pending. Bit b+3 sets on a frame start while pixels are pending.
- R4: Status bit b sets in the cycle after the run level of channel ch falls from 1 to 0. Bit b+4 sets on an end-of-line-N pulse and bit b+5 on a low-watermark pulse.
- R5: Writing 1 to a channel flag bit clears that flag, and writing 0 leaves it unchanged. A set condition in the same cycle as the clear keeps the flag at 1.
- R6: Writing 1 to status bit 0 clears all channel flags, the DMA flag (bit 7) and the profiler flag (bit 0). It leaves the response code unchanged.
- R7: Status bit 1+ch reads 1 when one of these holds: end-of-frame is set with control bit 7+2·ch; end-of-line-N is set with control bit 8+2·ch; underflow is set with control bit 13+ch; or short-frame is set. Short-line and low-watermark flags never contribute.
- R8: A DMA error pulse sets status bit 7, and status bit 4 reads bit 7 AND control bit 4. A profiler pulse sets status bit 0. A valid bus response stores its 2-bit code (0 OKAY, 2 SLVERR, 3 DECERR) in bits 15:14. Bit 7 is write-one-to-clear.
- R9: `irq_o` is a register. It is loaded with the OR of each summary bit ANDed with its control bit 1+ch, ORed with the profiler flag ANDed with control bit 0. It falls one cycle after the last source clears.
- R10: While control bit 31 is 0, no event, error, profiler pulse or bus response changes the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Word select: 0 control, 1 status |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected word, combinational |
| chan_run_i | input | 3 | Per-channel run mode level |
| rd_req_i | input | 3 | Per-channel downstream read request |
| fifo_empty_i | input | 3 | Per-channel display FIFO empty |
| line_start_i | input | 3 | Per-channel line start pulse |
| frame_start_i | input | 3 | Per-channel frame start pulse |
| pix_pend_i | input | 3 | Per-channel pixels of the current line outstanding |
| eoln_i | input | 3 | Per-channel end-of-line-N pulse |
| lowwm_i | input | 3 | Per-channel low-watermark pulse |
| dma_err_i | input | 1 | DMA ID error pulse |
| prof_i | input | 1 | Profiler event pulse |
| resp_valid_i | input | 1 | Bus response valid |
| resp_i | input | 2 | Bus response code |
| irq_o | output | 1 | Interrupt request, registered |

## Verification
A flag that is wrongly set, wrongly cleared or stuck is visible in the status word on the read port in the first cycle after the edge that caused it. It also shows up in the channel's summary bit in that same cycle. A wrong summary or enable decode reaches `irq_o` one edge later. An edge detector on the run level that lost its history would either miss the end-of-frame flag or raise it a cycle late, and that is visible on the next status read. A bad clear decode shows up as a flag that survives a clear-all, or as a flag lost when a set and a clear land together.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;
  localparam int NCH       = 3;
  localparam int NEV       = 6;
  localparam int DW        = 32;
  localparam int CH_BASE   = 8;
  localparam int CH_STRIDE = 8;
  localparam int RESP_LSB  = 14;

  localparam int EV_EOF    = 0;
  localparam int EV_UFLOW  = 1;
  localparam int EV_SLINE  = 2;
  localparam int EV_SFRAME = 3;
  localparam int EV_EOLN   = 4;
  localparam int EV_LOWWM  = 5;

  localparam int CTL_EN    = 31;
  localparam int CTL_PROF  = 0;
  localparam int CTL_DMA   = 4;
  localparam int ST_DMAERR = 7;
  localparam logic [DW-1:0] CTRL_WMASK = 32'h8000_FFFF;

  typedef logic [NEV-1:0] ev_vec_t;

  function automatic int eof_en_bit(input int ch);
    return 7 + 2 * ch;
  endfunction
  function automatic int eoln_en_bit(input int ch);
    return 8 + 2 * ch;
  endfunction
  function automatic int ur_en_bit(input int ch);
    return 13 + ch;
  endfunction
  function automatic int ch_base(input int ch);
    return CH_BASE + CH_STRIDE * ch;
  endfunction
endpackage

// File: rtl/disp_irq_chan.sv
module disp_irq_chan
  import disp_irq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    en_i,
  input  logic    run_i,
  input  logic    rd_req_i,
  input  logic    fifo_empty_i,
  input  logic    line_start_i,
  input  logic    frame_start_i,
  input  logic    pix_pend_i,
  input  logic    eoln_i,
  input  logic    lowwm_i,
  input  ev_vec_t clr_i,
  input  logic    clr_all_i,
  input  logic    en_eof_i,
  input  logic    en_eoln_i,
  input  logic    en_ur_i,
  output ev_vec_t flags_o,
  output logic    summ_o
);
  logic    run_q;
  ev_vec_t flags_q, set_ev, clr_ev;

  always_comb begin
    set_ev            = '0;
    set_ev[EV_EOF]    = run_q & ~run_i;
    set_ev[EV_UFLOW]  = rd_req_i & fifo_empty_i;
    set_ev[EV_SLINE]  = line_start_i & pix_pend_i;
    set_ev[EV_SFRAME] = frame_start_i & pix_pend_i;
    set_ev[EV_EOLN]   = eoln_i;
    set_ev[EV_LOWWM]  = lowwm_i;
    set_ev            = set_ev & {NEV{en_i}};
    clr_ev            = clr_i | {NEV{clr_all_i}};
  end

  // run history is tracked even while disabled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      flags_q <= '0;
    end else begin
      run_q   <= run_i;
      flags_q <= (flags_q & ~clr_ev) | set_ev;
    end
  end

  assign flags_o = flags_q;
  assign summ_o  = (flags_q[EV_EOF] & en_eof_i) | (flags_q[EV_EOLN] & en_eoln_i) |
                   (flags_q[EV_UFLOW] & en_ur_i) | flags_q[EV_SFRAME];

  p_uflow_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && rd_req_i && fifo_empty_i) |=> flags_o[EV_UFLOW]);
  p_eof_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !run_i && $past(run_i)) |=> flags_o[EV_EOF]);
  p_w1c_eoln_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i[EV_EOLN] && !(en_i && eoln_i)) |=> !flags_o[EV_EOLN]);
  p_hold_disabled_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && clr_i == '0 && !clr_all_i) |=> $stable(flags_o));
endmodule

// File: rtl/disp_irq_glob.sv
module disp_irq_glob
  import disp_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       dma_err_i,
  input  logic       prof_i,
  input  logic       resp_valid_i,
  input  logic [1:0] resp_i,
  input  logic       clr_dma_i,
  input  logic       clr_all_i,
  output logic       dma_o,
  output logic       prof_o,
  output logic [1:0] resp_o
);
  logic       dma_q, prof_q;
  logic [1:0] resp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dma_q  <= 1'b0;
      prof_q <= 1'b0;
      resp_q <= 2'd0;
    end else begin
      dma_q  <= (dma_q & ~(clr_dma_i | clr_all_i)) | (en_i & dma_err_i);
      prof_q <= (prof_q & ~clr_all_i) | (en_i & prof_i);
      if (en_i && resp_valid_i) resp_q <= resp_i;
    end
  end

  assign dma_o  = dma_q;
  assign prof_o = prof_q;
  assign resp_o = resp_q;

  p_resp_latch_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && resp_valid_i) |=> resp_o == $past(resp_i));
  p_resp_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_all_i && !resp_valid_i) |=> $stable(resp_o));
endmodule

// File: rtl/disp_irq_ctrl.sv
module disp_irq_ctrl
  import disp_irq_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_we_i,
  input  logic           reg_addr_i,
  input  logic [DW-1:0]  reg_wdata_i,
  output logic [DW-1:0]  reg_rdata_o,
  input  logic [NCH-1:0] chan_run_i,
  input  logic [NCH-1:0] rd_req_i,
  input  logic [NCH-1:0] fifo_empty_i,
  input  logic [NCH-1:0] line_start_i,
  input  logic [NCH-1:0] frame_start_i,
  input  logic [NCH-1:0] pix_pend_i,
  input  logic [NCH-1:0] eoln_i,
  input  logic [NCH-1:0] lowwm_i,
  input  logic           dma_err_i,
  input  logic           prof_i,
  input  logic           resp_valid_i,
  input  logic [1:0]     resp_i,
  output logic           irq_o
);
  logic [DW-1:0]  ctrl_q, status;
  logic [NCH-1:0] summ;
  ev_vec_t        flags [NCH];
  logic           st_wr, clr_all, en, dma_f, prof_f, irq_q;
  logic [1:0]     resp_f;

  assign st_wr   = reg_we_i & reg_addr_i;
  assign clr_all = st_wr & reg_wdata_i[0];
  assign en      = ctrl_q[CTL_EN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    ctrl_q <= '0;
    else if (reg_we_i && !reg_addr_i) ctrl_q <= reg_wdata_i & CTRL_WMASK;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int BASE = ch_base(c);
    disp_irq_chan u_chan (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .en_i         (en),
      .run_i        (chan_run_i[c]),
      .rd_req_i     (rd_req_i[c]),
      .fifo_empty_i (fifo_empty_i[c]),
      .line_start_i (line_start_i[c]),
      .frame_start_i(frame_start_i[c]),
      .pix_pend_i   (pix_pend_i[c]),
      .eoln_i       (eoln_i[c]),
      .lowwm_i      (lowwm_i[c]),
      .clr_i        (reg_wdata_i[BASE +: NEV] & {NEV{st_wr}}),
      .clr_all_i    (clr_all),
      .en_eof_i     (ctrl_q[eof_en_bit(c)]),
      .en_eoln_i    (ctrl_q[eoln_en_bit(c)]),
      .en_ur_i      (ctrl_q[ur_en_bit(c)]),
      .flags_o      (flags[c]),
      .summ_o       (summ[c])
    );
  end

  disp_irq_glob u_glob (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en),
    .dma_err_i   (dma_err_i),
    .prof_i      (prof_i),
    .resp_valid_i(resp_valid_i),
    .resp_i      (resp_i),
    .clr_dma_i   (st_wr & reg_wdata_i[ST_DMAERR]),
    .clr_all_i   (clr_all),
    .dma_o       (dma_f),
    .prof_o      (prof_f),
    .resp_o      (resp_f)
  );

  always_comb begin
    status          = '0;
    status[0]       = prof_f;
    status[NCH:1]   = summ;
    status[CTL_DMA] = dma_f & ctrl_q[CTL_DMA];
    status[ST_DMAERR] = dma_f;
    status[RESP_LSB +: 2] = resp_f;
    for (int c = 0; c < NCH; c++) status[ch_base(c) +: NEV] = flags[c];
  end

  assign reg_rdata_o = reg_addr_i ? status : ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= (|(summ & ctrl_q[NCH:1])) | (prof_f & ctrl_q[CTL_PROF]);
  end
  assign irq_o = irq_q;

  p_ctrl_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !reg_addr_i) |=> ctrl_q == ($past(reg_wdata_i) & CTRL_WMASK));
  p_irq_after_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_all && !en) |=> ##1 !irq_o);
  p_sframe_summ_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && frame_start_i[0] && pix_pend_i[0]) |=> status[1]);
endmodule

// File: tb/tb_disp_irq_ctrl.sv
`timescale 1ns/1ps
module tb_disp_irq_ctrl;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic we = 1'b0, addr = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic [2:0] run = '0, rdreq = '0, empty = '0, lst = '0, fst = '0, pend = '0, eol = '0, lwm = '0;
  logic dma_err = 1'b0, prof = 1'b0, rvalid = 1'b0, irq;
  logic [1:0] resp = '0;
  int n_chk = 0, n_fail = 0;

  // model state
  logic [31:0] ctrl_m;
  logic [5:0]  fl_m [3];
  logic        dma_m, prof_m, irq_m;
  logic [1:0]  resp_m;
  logic [2:0]  run_m;

  always #4 clk_i = ~clk_i;

  disp_irq_ctrl dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .chan_run_i(run), .rd_req_i(rdreq),
    .fifo_empty_i(empty), .line_start_i(lst), .frame_start_i(fst), .pix_pend_i(pend),
    .eoln_i(eol), .lowwm_i(lwm), .dma_err_i(dma_err), .prof_i(prof),
    .resp_valid_i(rvalid), .resp_i(resp), .irq_o(irq)
  );

  function automatic logic summ_m(input int c);
    return (fl_m[c][0] & ctrl_m[7+2*c]) | (fl_m[c][4] & ctrl_m[8+2*c]) |
           (fl_m[c][1] & ctrl_m[13+c]) | fl_m[c][3];
  endfunction

  function automatic logic [31:0] status_m();
    logic [31:0] s = '0;
    s[0] = prof_m;
    for (int c = 0; c < 3; c++) begin
      s[1+c] = summ_m(c);
      s[8+8*c +: 6] = fl_m[c];
    end
    s[4] = dma_m & ctrl_m[4];
    s[7] = dma_m;
    s[15:14] = resp_m;
    return s;
  endfunction

  task automatic expect_eq(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check(input string tag);
    we = 1'b0;
    addr = 1'b1; #1;
    expect_eq(tag, "status", rdata, status_m());
    addr = 1'b0; #1;
    expect_eq(tag, "ctrl", rdata, ctrl_m);
    expect_eq(tag, "irq", {31'd0, irq}, {31'd0, irq_m});
  endtask

  // one clock edge with the inputs currently driven
  task automatic tick();
    logic en, sw, ca;
    logic [5:0] set, clr;
    logic [5:0] fl_n [3];
    logic [2:0] s3;
    en = ctrl_m[31];
    sw = we & addr;
    ca = sw & wdata[0];
    for (int c = 0; c < 3; c++) begin
      s3[c] = summ_m(c);
      set = {lwm[c], eol[c], fst[c] & pend[c], lst[c] & pend[c], rdreq[c] & empty[c], run_m[c] & ~run[c]};
      set = set & {6{en}};
      clr = (sw ? wdata[8+8*c +: 6] : 6'd0) | {6{ca}};
      fl_n[c] = (fl_m[c] & ~clr) | set;
    end
    @(posedge clk_i);
    irq_m = (|(s3 & ctrl_m[3:1])) | (prof_m & ctrl_m[0]);
    for (int c = 0; c < 3; c++) fl_m[c] = fl_n[c];
    dma_m  = (dma_m & ~((sw & wdata[7]) | ca)) | (en & dma_err);
    prof_m = (prof_m & ~ca) | (en & prof);
    if (en && rvalid) resp_m = resp;
    run_m = run;
    if (we && !addr) ctrl_m = wdata & 32'h8000_FFFF;
    @(negedge clk_i);
  endtask

  task automatic quiet();
    we = 0; rdreq = '0; empty = '0; lst = '0; fst = '0; pend = '0; eol = '0; lwm = '0;
    dma_err = 0; prof = 0; rvalid = 0;
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0;
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    ctrl_m = '0; dma_m = 0; prof_m = 0; irq_m = 0; resp_m = '0; run_m = '0;
    for (int c = 0; c < 3; c++) fl_m[c] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    addr = 1; #1; expect_eq("R1", "status", rdata, 32'h0);
    addr = 0; #1; expect_eq("R1", "ctrl", rdata, 32'h0);
    expect_eq("R1", "irq", {31'd0, irq}, 32'h0);

    // R2 write mask
    wr(1'b0, 32'hFFFF_FFFF);
    addr = 0; #1; expect_eq("R2", "ctrl mask", rdata, 32'h8000_FFFF);
    check("R2");

    // R10 disabled block ignores everything
    wr(1'b0, 32'h0000_FFFF);
    run = 3'b111; tick();
    rdreq = '1; empty = '1; lst = '1; fst = '1; pend = '1; eol = '1; lwm = '1;
    dma_err = 1; prof = 1; rvalid = 1; resp = 2'd3; run = '0;
    tick(); quiet();
    addr = 1; #1; expect_eq("R10", "status", rdata, 32'h0);
    check("R10");

    // R7 short frame reaches summary without enables
    wr(1'b0, 32'h8000_0000);
    fst[1] = 1; pend[1] = 1; tick(); quiet();
    addr = 1; #1; expect_eq("R7", "sframe+summ", rdata, 32'h0008_0004);
    check("R7");
    // R3 underflow and short line
    rdreq[0] = 1; empty[0] = 1; lst[2] = 1; pend[2] = 1; tick(); quiet();
    check("R3");
    // R4 run fall, eoln, lowwm
    run[0] = 1; tick(); run[0] = 0; eol[1] = 1; lwm[2] = 1; tick(); quiet();
    addr = 1; #1; expect_eq("R4", "eof ch0", {31'd0, rdata[8]}, 32'd1);
    check("R4");

    // R5 set wins over clear, 0 no effect, 1 clears
    we = 1; addr = 1; wdata = 32'h0000_0200; rdreq[0] = 1; empty[0] = 1; tick(); quiet();
    check("R5");
    wr(1'b1, 32'h0); check("R5");
    wr(1'b1, 32'h0000_0200);
    addr = 1; #1; expect_eq("R5", "uflow cleared", {31'd0, rdata[9]}, 32'd0);
    check("R5");

    // R9 interrupt with all enables, R6 clear-all
    wr(1'b0, 32'h8000_FFFF);
    tick(); check("R9");
    dma_err = 1; prof = 1; rvalid = 1; resp = 2'd2; tick(); quiet();
    check("R8");
    wr(1'b1, 32'h0000_0001); check("R6");
    addr = 1; #1; expect_eq("R6", "resp kept", {30'd0, rdata[15:14]}, 32'd2);
    tick(); check("R9");
    expect_eq("R9", "irq low", {31'd0, irq}, 32'd0);

    // random
    for (int i = 0; i < 4000; i++) begin
      run = $urandom; rdreq = $urandom; empty = $urandom & $urandom;
      lst = $urandom & $urandom; fst = $urandom & $urandom & $urandom; pend = $urandom;
      eol = $urandom & $urandom & $urandom; lwm = $urandom & $urandom & $urandom;
      dma_err = ($urandom_range(0, 15) == 0); prof = ($urandom_range(0, 15) == 0);
      rvalid = $urandom; resp = $urandom;
      we = ($urandom_range(0, 5) == 0); addr = $urandom;
      wdata = $urandom;
      if (!addr && $urandom_range(0, 7) != 0) wdata[31] = 1'b1;
      if (addr && $urandom_range(0, 3) != 0) wdata[0] = 1'b0;
      tick();
      check((i % 2) ? "R7" : "R9");
    end
    finish_run();
  end
endmodule